// File: doc/BRIEF.md
# Free-Running Timestamp Counter

This block keeps a 40-bit count that only ever moves forward. It never reloads. While it is enabled it advances by one on each single-cycle pulse of a tick-enable input, nominally 983.04 kHz. It has no interrupt output. Software reaches it through a small request/response register port with two word registers:

- The low word at offset 0x60 returns the bottom 32 count bits.
- The high register at offset 0x64 returns the top 8 count bits in bits 7:0. Bit 8 of the same register is the enable.

A 40-bit value cannot be read in one access, so the block keeps a shadow of the upper bits. Reading the low word captures the upper count bits into that shadow. The next read of the high register returns the captured bits instead of the live ones. A low read followed by a high read therefore yields one consistent 40-bit value, even if a carry crossed the word boundary between the two accesses.

The request channel is valid/ready, and a request is taken on a cycle where both are high. Every accepted request, read or write, produces exactly one response on a valid/ready response channel. When the response consumer holds its ready low, the response stays on the port unchanged, and no new request is accepted until that response is taken. The width of the low count field is a parameter (default 32). The upper field is 8 bits by default.

Top module: `ts_stamp_timer`

## Requirements
- R1: After reset the count is zero and the enable is clear. A read of either register returns zero, `rsp_valid_o` is low and `req_ready_o` is high.
- R2: While the enable is clear, tick pulses leave the count unchanged.
- R3: A write to offset 0x64 sets the enable from write-data bit 8. A read of 0x64 returns that bit in bit 8. Writing the bit as 0 stops the count where it stands.
- R4: While enabled, the count rises by exactly one for each cycle in which the tick input is high.
- R5: A read of offset 0x60 returns the low LO_W count bits, zero-extended, and captures count bits [LO_W+7:LO_W]. The next read of 0x64 returns those captured bits in bits 7:0. A read of 0x64 with no capture pending returns the live upper bits.
- R6: Bits 31:9 of a 0x64 read are zero. Write-data bits other than bit 8 are ignored. Writes to 0x60 have no effect on the count.
- R7: The count wraps from all ones to zero, modulo 2^(LO_W+8).
- R8: A response appears on the cycle after its request is accepted. It stays valid and stable while `rsp_ready_i` is low. While such a response waits, `req_ready_o` is low.
- R9: A read of any offset other than 0x60 or 0x64 returns zero. Every write is answered with zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle count-enable pulse |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be taken this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Byte offset of the register |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response present |
| rsp_ready_i | input | 1 | Consumer takes the response this cycle |
| rsp_rdata_o | output | 32 | Read data (zero for writes) |

## Verification
Read data is registered, so it shows up one cycle after the accepting edge. It reflects the count as it stood before that edge, which means a tick on the accepting edge is not yet included. An enable write acts on ticks from the following edge onward. The bench samples the port handshake half a cycle before each edge and updates its reference count, enable and shadow at that edge using those samples. At acceptance it queues the expected word. A monitor then compares each response at the point where it is taken, and a stalled response is checked for stability over several cycles.

// File: rtl/ts_pkg.sv
`timescale 1ns/1ps
package ts_pkg;
  // register selected by a request offset
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LOW  = 2'd1,
    SEL_HIGH = 2'd2
  } ts_sel_e;
endpackage

// File: rtl/ts_count_core.sv
`timescale 1ns/1ps
module ts_count_core #(
  parameter int CNT_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step = en_i & tick_i;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (step) cnt_q <= cnt_q + 1'b1;   // wraps modulo 2^CNT_W
  end

  assign cnt_o = cnt_q;

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_i && tick_i) |=> $stable(cnt_o)); // R2
  AST_ONE_PER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && tick_i) |=> cnt_o == CNT_W'($past(cnt_o) + 1'b1)); // R4
endmodule

// File: rtl/ts_hi_shadow.sv
`timescale 1ns/1ps
module ts_hi_shadow #(
  parameter int HI_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_i,   // low word read accepted
  input  logic            use_i,   // high register read accepted
  input  logic [HI_W-1:0] live_i,
  output logic [HI_W-1:0] hi_o
);
  logic [HI_W-1:0] sh_q;
  logic            sh_vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q     <= '0;
      sh_vld_q <= 1'b0;
    end else if (cap_i) begin
      sh_q     <= live_i;
      sh_vld_q <= 1'b1;
    end else if (use_i) begin
      sh_vld_q <= 1'b0;
    end
  end

  assign hi_o = sh_vld_q ? sh_q : live_i;

  AST_SHADOW_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> sh_vld_q); // R5
  AST_SHADOW_SPENT: assert property (@(posedge clk) disable iff (!rst_n)
    (use_i && !cap_i) |=> !sh_vld_q); // R5
  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_i && use_i)); // R8
endmodule

// File: rtl/ts_bus_port.sv
`timescale 1ns/1ps
module ts_bus_port
  import ts_pkg::*;
#(
  parameter int                ADDR_W = 8,
  parameter int                DATA_W = 32,
  parameter int                LO_W   = 32,
  parameter int                HI_W   = 8,
  parameter logic [ADDR_W-1:0] LO_OFS = ADDR_W'('h60),
  parameter logic [ADDR_W-1:0] HI_OFS = ADDR_W'('h64)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [DATA_W-1:0] rsp_rdata_o,
  input  logic [LO_W-1:0]   cnt_lo_i,
  input  logic [HI_W-1:0]   hi_val_i,
  output logic              en_o,
  output logic              cap_o,
  output logic              use_o
);
  localparam int EN_BIT = HI_W;

  ts_sel_e           sel;
  logic              acc, rd_lo, rd_hi, wr_hi;
  logic              en_q, rsp_vld_q;
  logic [DATA_W-1:0] rsp_q, lo_word, hi_word, rd_next;
  logic              unused_wbits;

  always_comb begin
    if (req_addr_i == LO_OFS)      sel = SEL_LOW;
    else if (req_addr_i == HI_OFS) sel = SEL_HIGH;
    else                           sel = SEL_NONE;
  end

  assign req_ready_o  = !rsp_vld_q || rsp_ready_i;
  assign acc          = req_valid_i && req_ready_o;
  assign rd_lo        = acc && !req_write_i && (sel == SEL_LOW);
  assign rd_hi        = acc && !req_write_i && (sel == SEL_HIGH);
  assign wr_hi        = acc &&  req_write_i && (sel == SEL_HIGH);
  assign unused_wbits = ^req_wdata_i;

  always_comb begin
    lo_word             = '0;
    lo_word[LO_W-1:0]   = cnt_lo_i;
    hi_word             = '0;
    hi_word[HI_W-1:0]   = hi_val_i;
    hi_word[EN_BIT]     = en_q;
    if (rd_lo)      rd_next = lo_word;
    else if (rd_hi) rd_next = hi_word;
    else            rd_next = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     en_q <= 1'b0;
    else if (wr_hi) en_q <= req_wdata_i[EN_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vld_q <= 1'b0;
      rsp_q     <= '0;
    end else if (acc) begin
      rsp_vld_q <= 1'b1;
      rsp_q     <= rd_next;
    end else if (rsp_ready_i) begin
      rsp_vld_q <= 1'b0;
    end
  end

  assign rsp_valid_o = rsp_vld_q;
  assign rsp_rdata_o = rsp_q;
  assign en_o        = en_q;
  assign cap_o       = rd_lo;
  assign use_o       = rd_hi;

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o) |=> rsp_valid_o); // R8
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_rdata_o))); // R8
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |-> !req_ready_o); // R8
  AST_HI_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi |=> rsp_rdata_o[DATA_W-1:EN_BIT+1] == '0); // R6
  AST_WRITE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write_i) |=> rsp_rdata_o == '0); // R9
endmodule

// File: rtl/ts_stamp_timer.sv
`timescale 1ns/1ps
module ts_stamp_timer #(
  parameter int                ADDR_W = 8,
  parameter int                DATA_W = 32,
  parameter int                LO_W   = 32,
  parameter int                HI_W   = 8,
  parameter logic [ADDR_W-1:0] LO_OFS = ADDR_W'('h60),
  parameter logic [ADDR_W-1:0] HI_OFS = ADDR_W'('h64)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [DATA_W-1:0] rsp_rdata_o
);
  localparam int CNT_W = LO_W + HI_W;

  logic [CNT_W-1:0] cnt;
  logic [HI_W-1:0]  hi_val;
  logic             en, cap, use_sh;

  ts_count_core #(.CNT_W(CNT_W)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (en),
    .tick_i (tick_i),
    .cnt_o  (cnt)
  );

  ts_hi_shadow #(.HI_W(HI_W)) u_shadow (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_i  (cap),
    .use_i  (use_sh),
    .live_i (cnt[CNT_W-1:LO_W]),
    .hi_o   (hi_val)
  );

  ts_bus_port #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LO_W   (LO_W),
    .HI_W   (HI_W),
    .LO_OFS (LO_OFS),
    .HI_OFS (HI_OFS)
  ) u_port (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_ready_i (rsp_ready_i),
    .rsp_rdata_o (rsp_rdata_o),
    .cnt_lo_i    (cnt[LO_W-1:0]),
    .hi_val_i    (hi_val),
    .en_o        (en),
    .cap_o       (cap),
    .use_o       (use_sh)
  );
endmodule

// File: tb/ts_stamp_timer_tb.sv
`timescale 1ns/1ps
module ts_stamp_timer_tb;
  localparam int LW = 6;
  localparam int HW = 8;
  localparam int CW = LW + HW;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;

  ts_stamp_timer #(.LO_W(LW), .HI_W(HW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_rdata_o(rsp_rdata)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int tick_mode = 0;   // 0 off, 1 every cycle, 2 every third cycle
  string cur_tag = "R1";

  logic [31:0] exp_q[$];
  string       tag_q[$];

  // reference state, from the requirements
  logic [CW-1:0] m_cnt;
  logic          m_en, m_shv;
  logic [HW-1:0] m_sh;

  // handshake samples taken half a cycle before each edge
  logic        s_acc = 1'b0, s_write = 1'b0, s_tick = 1'b0;
  logic [7:0]  s_addr = '0;
  logic [31:0] s_wdata = '0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= '0; m_en <= 1'b0; m_shv <= 1'b0; m_sh <= '0;
    end else begin
      if (s_acc) begin
        tag_q.push_back(cur_tag);
        if (s_write) begin
          exp_q.push_back(32'h0);
          if (s_addr == 8'h64) m_en <= s_wdata[8];
        end else if (s_addr == 8'h60) begin
          exp_q.push_back({26'h0, m_cnt[LW-1:0]});
          m_sh  <= m_cnt[CW-1:LW];
          m_shv <= 1'b1;
        end else if (s_addr == 8'h64) begin
          exp_q.push_back({23'h0, m_en, (m_shv ? m_sh : m_cnt[CW-1:LW])});
          m_shv <= 1'b0;
        end else begin
          exp_q.push_back(32'h0);
        end
      end
      if (m_en && s_tick) m_cnt <= m_cnt + 1'b1;
    end
  end

  // tick driver
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % 3;
      tick = (tick_mode == 1) || (tick_mode == 2 && ph == 0);
    end
  end

  // sampler and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      s_acc = req_valid && req_ready; s_write = req_write; s_addr = req_addr;
      s_wdata = req_wdata; s_tick = tick;
      if (rst_n && rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R8 actual=unexpected response %h expected=none", rsp_rdata);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, rsp_rdata, e);
        end
      end
    end
  end

  task automatic bus(input logic w, input logic [7:0] a, input logic [31:0] d);
    logic got;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    got = 1'b0;
    while (!got) begin
      #1; got = req_ready;
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    repeat (5) @(negedge clk);
    #1;
    check("R1", {31'h0, rsp_valid}, 32'h0);
    check("R1", {31'h0, req_ready}, 32'h1);
    rst_n = 1'b1;
    cur_tag = "R1"; bus(0, 8'h60, 0); bus(0, 8'h64, 0); drain();

    tick_mode = 1; repeat (20) @(negedge clk);        // R2: disabled, ticks ignored
    cur_tag = "R2"; bus(0, 8'h60, 0); bus(0, 8'h64, 0); drain();
    check("R2", exp_q.size(), 0);

    cur_tag = "R3"; bus(1, 8'h64, 32'h100); bus(0, 8'h64, 0); drain();

    tick_mode = 2; repeat (40) @(negedge clk);        // R4: gapped ticks
    cur_tag = "R4"; bus(0, 8'h60, 0); repeat (10) @(negedge clk); bus(0, 8'h60, 0); drain();

    tick_mode = 1; repeat (100) @(negedge clk);       // R5: shadow vs live
    cur_tag = "R5"; bus(0, 8'h60, 0); repeat (70) @(negedge clk);
    bus(0, 8'h64, 0); bus(0, 8'h64, 0); drain();

    cur_tag = "R6"; bus(1, 8'h60, 32'hFFFF_FFFF); bus(1, 8'h64, 32'hFFFF_FFFF);
    bus(0, 8'h64, 0); bus(0, 8'h60, 0); drain();

    cur_tag = "R9"; bus(0, 8'h10, 0); bus(1, 8'h20, 32'h1234_5678); drain();

    cur_tag = "R3"; bus(1, 8'h64, 32'h0); bus(0, 8'h60, 0);
    repeat (30) @(negedge clk); bus(0, 8'h60, 0); bus(0, 8'h64, 0); drain();

    cur_tag = "R7"; bus(1, 8'h64, 32'h100); bus(0, 8'h60, 0); bus(0, 8'h64, 0);
    repeat (16390) @(negedge clk);
    bus(0, 8'h60, 0); bus(0, 8'h64, 0); drain();

    tick_mode = 0; rsp_ready = 1'b0; cur_tag = "R8";
    bus(0, 8'h64, 0);
    #1;
    check("R8", {31'h0, rsp_valid}, 32'h1);
    check("R8", {31'h0, req_ready}, 32'h0);
    held = rsp_rdata;
    repeat (3) @(negedge clk);
    #1;
    check("R8", {31'h0, rsp_valid}, 32'h1);
    check("R8", rsp_rdata, held);
    rsp_ready = 1'b1;
    drain();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule